// File: doc/BRIEF.md
# Two-Wire Slave Address Matcher

This block sits behind the bit-level receiver of a two-wire serial slave. It looks at each address byte that arrives after a start or a repeated start and decides, one byte at a time, whether the slave acknowledges it. It handles three kinds of addressing. In short addressing, seven address bits are followed by a direction bit. In long addressing there are ten address bits, sent as a header byte and a low byte. The third kind is the broadcast (general-call) address. The matcher reports a per-byte acknowledge decision, a selected flag, a read-request flag and the direction of the current transfer.

A single 16-bit address register holds either format. When its top five bits hold the pattern 11110, the register is treated as a 10-bit address and the matcher expects a two-byte address phase. Otherwise, bits [15:9] are the 7-bit address. Once the slave is selected, later bytes are data and get no decision from this block. A 10-bit read needs a write-addressed selection first, followed by a repeated start and the header byte with the read bit set. The selected and read-request flags stay set until software clears them with a write-one-to-clear strobe. A stop condition also drops the selected flag.

Top module: `tw_addr_match`

## Requirements
- R1: After reset, ackValid, ackOut, selected, readReq and dirRead are all 0.
- R2: In 7-bit mode (slaveAddr[15:11] != 11110), a first byte after a start whose bits [7:1] equal slaveAddr[15:9] produces ackValid=1 with ackOut=1 on the cycle after byteDone. It sets selected, and dirRead takes byte bit 0 (1 = master read).
- R3: A first byte that does not match produces ackValid=1 with ackOut=0. All following bytes produce no ackValid until a stop, and after the next start a matching byte is acknowledged again.
- R4: In 10-bit mode (slaveAddr[15:11] == 11110), the first byte {11110, slaveAddr[10:9], 0} is acknowledged without selecting. A following byte equal to slaveAddr[7:0] is acknowledged, sets selected and sets dirRead=0. slaveAddr[8] has no effect.
- R5: In 10-bit mode, a header byte with the wrong two address bits, or a second byte not equal to slaveAddr[7:0], is not acknowledged and leaves selected at 0.
- R6: After a 10-bit selection, a repeated start followed by {11110, slaveAddr[10:9], 1} is acknowledged. It sets dirRead=1 and readReq=1.
- R7: The byte 00h as first byte is acknowledged only when genCallEn=1. If acknowledged, it selects the slave with dirRead=0.
- R8: The byte 01h as first byte is never acknowledged, even when slaveAddr[15:9] is all zeros and genCallEn=1.
- R9: A 7-bit match with byte bit 0 = 1 sets readReq together with selected.
- R10: flagClr[0]=1 clears selected and flagClr[1]=1 clears readReq. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R11: stopDet clears selected and dirRead on the next cycle. readReq keeps its value.
- R12: Bytes received while selected in the data phase produce no ackValid.
- R13: In 10-bit mode, a header byte with bit 0 = 1 straight after a start, with no earlier selection, is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slaveAddr | input | 16 | Programmed slave address field (7-bit or 10-bit layout) |
| genCallEn | input | 1 | Acknowledge the general-call byte 00h |
| startDet | input | 1 | Start condition seen (one-cycle pulse) |
| rstartDet | input | 1 | Repeated start condition seen (one-cycle pulse) |
| stopDet | input | 1 | Stop condition seen (one-cycle pulse) |
| byteDone | input | 1 | rxByte holds a complete received byte (one-cycle pulse) |
| rxByte | input | 8 | Received byte, MSB first on the wire |
| flagClr | input | 2 | Write-one-to-clear: bit 0 selected, bit 1 readReq |
| ackValid | output | 1 | Acknowledge decision present for the last address byte |
| ackOut | output | 1 | 1 = acknowledge, 0 = not acknowledge (valid with ackValid) |
| selected | output | 1 | Sticky: slave has been addressed |
| readReq | output | 1 | Sticky: master has requested a read |
| dirRead | output | 1 | Direction of the current selection, 1 = slave transmits |

## Verification
A matching read address byte can arrive in the same cycle as a software clear of the selected and read-request flags. The bench provokes this by pulsing flagClr=11 together with byteDone on a matching read byte. It then expects both flags to read 1 on the following cycle. A clear issued alone afterwards must bring both flags to 0. A stop arriving in the same cycle as a byte is also covered by the checker: selected must be 0 on the next cycle.

// File: rtl/tw_addr_pkg.sv
package tw_addr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int PFX_W  = 5;
  localparam int FLAG_W = 2;
  localparam logic [PFX_W-1:0] TEN_PFX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_SECOND, ST_SEL, ST_REFIRST, ST_SKIP
  } phase_t;

  typedef struct packed {
    logic ackGo;
    logic nackGo;
    logic selSet;
    logic readSet;
    logic dirVal;
    logic stopClr;
  } strobe_t;

  typedef struct packed {
    logic isGenCall;
    logic isStartByte;
    logic hit7;
    logic hitHead;
    logic hitLow;
    logic rwBit;
    logic tenMode;
  } match_t;
endpackage

// File: rtl/tw_addr_dp.sv
module tw_addr_dp
  import tw_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [FLAG_W-1:0] flagClr,
  input  strobe_t           stb,
  output match_t            m,
  output logic              ackValid,
  output logic              ackOut,
  output logic              selected,
  output logic              readReq,
  output logic              dirRead
);
  localparam int HI_LSB = ADDR_W - (BYTE_W - 1);
  localparam int PFX_LSB = ADDR_W - PFX_W;

  logic unusedBit8;
  assign unusedBit8 = slaveAddr[BYTE_W];

  always_comb begin
    m.tenMode     = (slaveAddr[ADDR_W-1:PFX_LSB] == TEN_PFX);
    m.hit7        = (rxByte[BYTE_W-1:1] == slaveAddr[ADDR_W-1:HI_LSB]);
    m.hitHead     = (rxByte[BYTE_W-1:1] == {TEN_PFX, slaveAddr[BYTE_W+2:BYTE_W+1]});
    m.hitLow      = (rxByte == slaveAddr[BYTE_W-1:0]);
    m.isGenCall   = (rxByte == BYTE_W'(0));
    m.isStartByte = (rxByte == BYTE_W'(1));
    m.rwBit       = rxByte[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      ackOut   <= 1'b0;
      selected <= 1'b0;
      readReq  <= 1'b0;
      dirRead  <= 1'b0;
    end else begin
      ackValid <= stb.ackGo | stb.nackGo;
      ackOut   <= stb.ackGo;
      if (stb.stopClr)     selected <= 1'b0;
      else if (stb.selSet) selected <= 1'b1;
      else if (flagClr[0]) selected <= 1'b0;
      if (stb.readSet)     readReq <= 1'b1;
      else if (flagClr[1]) readReq <= 1'b0;
      if (stb.stopClr)     dirRead <= 1'b0;
      else if (stb.selSet) dirRead <= stb.dirVal;
    end
  end
endmodule

// File: rtl/tw_addr_ctl.sv
module tw_addr_ctl
  import tw_addr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startDet,
  input  logic    rstartDet,
  input  logic    stopDet,
  input  logic    byteDone,
  input  logic    genCallEn,
  input  match_t  m,
  output strobe_t stb
);
  phase_t state, stateNxt;
  logic   tenSel, tenSelNxt;

  always_comb begin
    stb       = '0;
    stateNxt  = state;
    tenSelNxt = tenSel;
    if (stopDet) begin
      stb.stopClr = 1'b1;
      stateNxt    = ST_IDLE;
      tenSelNxt   = 1'b0;
    end else if (startDet || rstartDet) begin
      if (rstartDet && state == ST_SEL && tenSel) begin
        stateNxt = ST_REFIRST;
      end else begin
        stateNxt  = ST_FIRST;
        tenSelNxt = 1'b0;
      end
    end else if (byteDone) begin
      unique case (state)
        ST_FIRST: begin
          if (m.isGenCall) begin
            if (genCallEn) begin
              stb.ackGo = 1'b1; stb.selSet = 1'b1; stateNxt = ST_SEL;
            end else begin
              stb.nackGo = 1'b1; stateNxt = ST_SKIP;
            end
          end else if (m.isStartByte) begin
            stb.nackGo = 1'b1; stateNxt = ST_SKIP;
          end else if (m.tenMode) begin
            if (m.hitHead && !m.rwBit) begin
              stb.ackGo = 1'b1; stateNxt = ST_SECOND;
            end else begin
              stb.nackGo = 1'b1; stateNxt = ST_SKIP;
            end
          end else if (m.hit7) begin
            stb.ackGo   = 1'b1;
            stb.selSet  = 1'b1;
            stb.dirVal  = m.rwBit;
            stb.readSet = m.rwBit;
            stateNxt    = ST_SEL;
          end else begin
            stb.nackGo = 1'b1; stateNxt = ST_SKIP;
          end
        end
        ST_SECOND: begin
          if (m.hitLow) begin
            stb.ackGo = 1'b1; stb.selSet = 1'b1;
            tenSelNxt = 1'b1; stateNxt = ST_SEL;
          end else begin
            stb.nackGo = 1'b1; stateNxt = ST_SKIP;
          end
        end
        ST_REFIRST: begin
          if (m.hitHead && m.rwBit) begin
            stb.ackGo   = 1'b1;
            stb.selSet  = 1'b1;
            stb.dirVal  = 1'b1;
            stb.readSet = 1'b1;
            stateNxt    = ST_SEL;
          end else if (m.hitHead) begin
            stb.ackGo = 1'b1; tenSelNxt = 1'b0; stateNxt = ST_SECOND;
          end else begin
            stb.nackGo = 1'b1; tenSelNxt = 1'b0; stateNxt = ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tenSel <= 1'b0;
    end else begin
      state  <= stateNxt;
      tenSel <= tenSelNxt;
    end
  end
endmodule

// File: rtl/tw_addr_match.sv
module tw_addr_match
  import tw_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic              genCallEn,
  input  logic              startDet,
  input  logic              rstartDet,
  input  logic              stopDet,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [FLAG_W-1:0] flagClr,
  output logic              ackValid,
  output logic              ackOut,
  output logic              selected,
  output logic              readReq,
  output logic              dirRead
);
  strobe_t stb;
  match_t  m;

  tw_addr_ctl i_ctl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .rstartDet(rstartDet),
    .stopDet(stopDet), .byteDone(byteDone), .genCallEn(genCallEn),
    .m(m), .stb(stb)
  );

  tw_addr_dp i_dp (
    .clk(clk), .rstN(rstN), .slaveAddr(slaveAddr), .rxByte(rxByte),
    .flagClr(flagClr), .stb(stb), .m(m), .ackValid(ackValid),
    .ackOut(ackOut), .selected(selected), .readReq(readReq),
    .dirRead(dirRead)
  );
endmodule

// File: rtl/tw_addr_match_chk.sv
module tw_addr_match_chk
  import tw_addr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] slaveAddr,
  input logic              genCallEn,
  input logic              startDet,
  input logic              rstartDet,
  input logic              stopDet,
  input logic              byteDone,
  input logic [BYTE_W-1:0] rxByte,
  input logic [FLAG_W-1:0] flagClr,
  input logic              ackValid,
  input logic              ackOut,
  input logic              selected,
  input logic              readReq,
  input logic              dirRead
);
  // R2
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(byteDone));

  // R2
  sel_rise_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selected) |-> (ackValid && ackOut));

  // R9
  read_req_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readReq) |-> (selected && dirRead));

  // R11
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!selected && !dirRead));

  // R10
  read_fall_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readReq) |-> $past(flagClr[1]));
endmodule

bind tw_addr_match tw_addr_match_chk i_chk (.*);

// File: tb/test_tw_addr_match.sv
`timescale 1ns/1ps
module test_tw_addr_match;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] slaveAddr = '0;
  logic        genCallEn = 1'b0;
  logic        startDet = 1'b0, rstartDet = 1'b0, stopDet = 1'b0, byteDone = 1'b0;
  logic [7:0]  rxByte = '0;
  logic [1:0]  flagClr = '0;
  logic        ackValid, ackOut, selected, readReq, dirRead;
  int          nRun = 0, nFail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  tw_addr_match i_tw_addr_match (
    .clk(clk), .rstN(rstN), .slaveAddr(slaveAddr), .genCallEn(genCallEn),
    .startDet(startDet), .rstartDet(rstartDet), .stopDet(stopDet),
    .byteDone(byteDone), .rxByte(rxByte), .flagClr(flagClr),
    .ackValid(ackValid), .ackOut(ackOut), .selected(selected),
    .readReq(readReq), .dirRead(dirRead)
  );

  task automatic check(string req, string what, logic act, logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); startDet = 1'b1;
    @(negedge clk); startDet = 1'b0;
  endtask

  task automatic pulseRstart();
    @(negedge clk); rstartDet = 1'b1;
    @(negedge clk); rstartDet = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopDet = 1'b1;
    @(negedge clk); stopDet = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] b, logic [1:0] clr = 2'b00);
    @(negedge clk); rxByte = b; byteDone = 1'b1; flagClr = clr;
    @(negedge clk); byteDone = 1'b0; flagClr = 2'b00;
  endtask

  task automatic clearFlags(logic [1:0] clr);
    @(negedge clk); flagClr = clr;
    @(negedge clk); flagClr = 2'b00;
  endtask

  task automatic expectAck(string req, logic exp);
    check(req, "ackValid", ackValid, 1'b1);
    check(req, "ackOut", ackOut, exp);
  endtask

  task automatic tReset();
    check("R1", "ackValid", ackValid, 1'b0);
    check("R1", "ackOut", ackOut, 1'b0);
    check("R1", "selected", selected, 1'b0);
    check("R1", "readReq", readReq, 1'b0);
    check("R1", "dirRead", dirRead, 1'b0);
  endtask

  task automatic t7Write();
    slaveAddr = {7'h52, 9'h0};
    pulseStart();
    sendByte(8'hA4);
    expectAck("R2", 1'b1);
    check("R2", "selected", selected, 1'b1);
    check("R2", "dirRead", dirRead, 1'b0);
    check("R2", "readReq", readReq, 1'b0);
    sendByte(8'hA4);
    check("R12", "ackValid data", ackValid, 1'b0);
    pulseStop();
    check("R11", "selected after stop", selected, 1'b0);
  endtask

  task automatic t7Read();
    pulseStart();
    sendByte(8'hA5);
    expectAck("R9", 1'b1);
    check("R9", "readReq", readReq, 1'b1);
    check("R2", "dirRead", dirRead, 1'b1);
    pulseStop();
    check("R11", "selected", selected, 1'b0);
    check("R11", "dirRead", dirRead, 1'b0);
    check("R11", "readReq kept", readReq, 1'b1);
    clearFlags(2'b10);
    check("R10", "readReq cleared", readReq, 1'b0);
  endtask

  task automatic tMiss();
    pulseStart();
    sendByte(8'hA6);
    expectAck("R3", 1'b0);
    check("R3", "selected", selected, 1'b0);
    sendByte(8'hA4);
    check("R3", "ignored ackValid", ackValid, 1'b0);
    check("R3", "ignored selected", selected, 1'b0);
    pulseStop();
    pulseStart();
    sendByte(8'hA4);
    expectAck("R3", 1'b1);
    pulseStop();
  endtask

  task automatic tGenCall();
    genCallEn = 1'b0;
    pulseStart();
    sendByte(8'h00);
    expectAck("R7", 1'b0);
    check("R7", "selected off", selected, 1'b0);
    pulseStop();
    genCallEn = 1'b1;
    pulseStart();
    sendByte(8'h00);
    expectAck("R7", 1'b1);
    check("R7", "selected on", selected, 1'b1);
    check("R7", "dirRead", dirRead, 1'b0);
    pulseStop();
  endtask

  task automatic tStartByte();
    slaveAddr = 16'h0000;
    genCallEn = 1'b1;
    pulseStart();
    sendByte(8'h01);
    expectAck("R8", 1'b0);
    check("R8", "selected", selected, 1'b0);
    pulseStop();
    genCallEn = 1'b0;
  endtask

  task automatic t10Write();
    slaveAddr = 16'hF53C;
    pulseStart();
    sendByte(8'hF4);
    expectAck("R4", 1'b1);
    check("R4", "not yet selected", selected, 1'b0);
    sendByte(8'h3C);
    expectAck("R4", 1'b1);
    check("R4", "selected", selected, 1'b1);
    check("R4", "dirRead", dirRead, 1'b0);
    pulseStop();
  endtask

  task automatic t10Miss();
    pulseStart();
    sendByte(8'hF4);
    sendByte(8'h3D);
    expectAck("R5", 1'b0);
    check("R5", "selected low", selected, 1'b0);
    pulseStop();
    pulseStart();
    sendByte(8'hF2);
    expectAck("R5", 1'b0);
    pulseStop();
    pulseStart();
    sendByte(8'hF5);
    expectAck("R13", 1'b0);
    check("R13", "readReq", readReq, 1'b0);
    pulseStop();
  endtask

  task automatic t10Read();
    pulseStart();
    sendByte(8'hF4);
    sendByte(8'h3C);
    check("R6", "selected", selected, 1'b1);
    pulseRstart();
    sendByte(8'hF5);
    expectAck("R6", 1'b1);
    check("R6", "dirRead", dirRead, 1'b1);
    check("R6", "readReq", readReq, 1'b1);
    pulseStop();
    clearFlags(2'b10);
  endtask

  task automatic tClrRace();
    slaveAddr = {7'h52, 9'h0};
    pulseStart();
    sendByte(8'hA5, 2'b11);
    check("R10", "selected set wins", selected, 1'b1);
    check("R10", "readReq set wins", readReq, 1'b1);
    clearFlags(2'b11);
    check("R10", "selected cleared", selected, 1'b0);
    check("R10", "readReq cleared", readReq, 1'b0);
    pulseStop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    t7Write();
    t7Read();
    tMiss();
    tGenCall();
    tStartByte();
    t10Write();
    t10Miss();
    t10Read();
    tClrRace();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule